// File: doc/BRIEF.md
# LCD Panel Timing Generator

This block produces the scan timing for a parallel LCD panel from a set of 16-bit control registers written over a simple synchronous register bus. It counts pixels and lines, and from those counts it drives a line sync, a frame sync and a display-enable window. It also brings out the pixel and line counts so that a downstream fetch unit can follow the scan. Horizontal quantities are programmed in 8-pixel character units. Every size and position field holds its value minus one.

Software sets the geometry while the display is off and then sets the display-on bit. A 2-bit power state then climbs one step per programmable interval. Scanning starts only when that state reaches fully on. Clearing the display-on bit stops the scan at once, and the power state then walks back down to off. Software polls the power state to learn when either transition has finished. A frame-start interrupt pulse can be enabled. Geometry and polarity writes go to staging registers, and the scanner uses them only from the next frame boundary, so no frame is torn.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset the power state reads 0. Sync, enable, interrupt and panel-enable outputs are 0, both counts are 0, every geometry register reads 0 and the step-delay register reads its reset parameter.
- R2: Register map, by word address. 0 control. 1 mode. 2 interrupt enable. 3 horizontal count: [7:0] = total chars − 1, [15:8] = active chars − 1. 4 active lines − 1. 5 total lines − 1. 6 frame sync: [11:0] = start line − 1, [15:12] = width − 1. 7 line sync: [11:0] = start char − 1, [15:12] = width chars − 1. 8 power state in [1:0]. 9 step delay. Geometry registers read back the written fields, and the vertical registers read 0 in [15:12].
- R3: The pixel count runs 0 to 8·(total chars) − 1, and the line count advances when the pixel count wraps and runs 0 to total lines − 1. The enable output is high only when pixel < 8·(active chars) and line < active lines.
- R4: Line sync is asserted for pixels from 8·start char up to, but not including, 8·(start char + width chars). Frame sync is asserted for lines from the start line up to, but not including, start line + width.
- R5: Mode bit 0 set makes line sync active-low, and mode bit 1 set makes frame sync active-low. A sync that is not asserted sits at its inactive level.
- R6: Control bit 0 is display on. Control bit 1 is the second enable and drives panel_en_o directly.
- R7: While display on is set, the power state rises 0→1→2→3. While it is clear, the state falls 3→2→1→0. Each step takes (step delay + 1) clocks.
- R8: Unless display on is set and the power state is 3, both counts are held at 0, the enable output is 0 and both syncs sit at their inactive level. Clearing display on stops scanning with the next clock.
- R9: When interrupt-enable bit 0 is set, irq_o is high for exactly the first cycle of each frame (pixel 0, line 0). The enable bit takes effect immediately.
- R10: Mode and geometry writes read back at once but reach the outputs only from the next frame start. A write in the last cycle of a frame applies to the frame that follows it. While scanning is stopped, writes apply at once.
- R11: Writes to the power-state address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for reg_addr_i (combinational) |
| hsync_o | output | 1 | Line sync |
| vsync_o | output | 1 | Frame sync |
| de_o | output | 1 | Display-enable window |
| pix_x_o | output | 11 | Pixel count within the line |
| line_o | output | 12 | Line count within the frame |
| irq_o | output | 1 | Frame-start interrupt pulse |
| panel_en_o | output | 1 | Second enable bit from the control register |

## Verification
A register write and the frame-boundary copy from staging to the live timing can happen on the same clock edge. The bench waits until the last pixel of the last line and writes the mode register in that cycle. It then checks that the line-sync polarity of the very next frame already follows the new value. A separate mid-frame write checks that the old polarity holds until the end of the current frame and that the new one appears at the following frame start.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 4;
  localparam int CHAR_W = 8;
  localparam int SUB_W  = 3;
  localparam int PIX_W  = CHAR_W + SUB_W;
  localparam int LINE_W = 12;
  localparam int HPOS_W = 12;
  localparam int WID_W  = 4;
  localparam int PWR_W  = 2;
  localparam int DLY_W  = 16;
  localparam int CMP_W  = HPOS_W + 1;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_MODE  = 4'd1;
  localparam logic [ADDR_W-1:0] A_IRQ   = 4'd2;
  localparam logic [ADDR_W-1:0] A_HCNT  = 4'd3;
  localparam logic [ADDR_W-1:0] A_VACT  = 4'd4;
  localparam logic [ADDR_W-1:0] A_VTOT  = 4'd5;
  localparam logic [ADDR_W-1:0] A_VSYNC = 4'd6;
  localparam logic [ADDR_W-1:0] A_HSYNC = 4'd7;
  localparam logic [ADDR_W-1:0] A_PWR   = 4'd8;
  localparam logic [ADDR_W-1:0] A_STEP  = 4'd9;

  localparam logic [PWR_W-1:0] PWR_FULL = 2'd3;

  typedef struct packed {
    logic              hs_low;
    logic              vs_low;
    logic [CHAR_W-1:0] htot;
    logic [CHAR_W-1:0] hact;
    logic [LINE_W-1:0] vact;
    logic [LINE_W-1:0] vtot;
    logic [HPOS_W-1:0] vs_beg;
    logic [WID_W-1:0]  vs_wid;
    logic [HPOS_W-1:0] hs_beg;
    logic [WID_W-1:0]  hs_wid;
  } tmg_t;
endpackage

// File: rtl/lcdt_regs.sv
module lcdt_regs
  import lcdt_pkg::*;
#(
  parameter logic [DLY_W-1:0] STEP_RST = 16'd3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              commit_i,
  input  logic [PWR_W-1:0]  pwr_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              disp_on_o,
  output logic              aux_en_o,
  output logic              irq_en_o,
  output logic [DLY_W-1:0]  step_dly_o,
  output tmg_t              act_o
);
  tmg_t stg_q, stg_d, act_q;
  logic [DLY_W-1:0] step_q;
  logic disp_q, aux_q, irq_q;

  always_comb begin
    stg_d = stg_q;
    if (wr_i) begin
      case (addr_i)
        A_MODE:  begin stg_d.hs_low = wdata_i[0]; stg_d.vs_low = wdata_i[1]; end
        A_HCNT:  begin stg_d.htot = wdata_i[7:0]; stg_d.hact = wdata_i[15:8]; end
        A_VACT:  stg_d.vact = wdata_i[LINE_W-1:0];
        A_VTOT:  stg_d.vtot = wdata_i[LINE_W-1:0];
        A_VSYNC: begin stg_d.vs_beg = wdata_i[11:0]; stg_d.vs_wid = wdata_i[15:12]; end
        A_HSYNC: begin stg_d.hs_beg = wdata_i[11:0]; stg_d.hs_wid = wdata_i[15:12]; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q  <= '0;
      act_q  <= '0;
      step_q <= STEP_RST;
      disp_q <= 1'b0;
      aux_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      stg_q <= stg_d;
      // staging written in the boundary cycle goes straight through
      if (commit_i) act_q <= stg_d;
      if (wr_i) begin
        case (addr_i)
          A_CTRL: begin disp_q <= wdata_i[0]; aux_q <= wdata_i[1]; end
          A_IRQ:  irq_q  <= wdata_i[0];
          A_STEP: step_q <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr_i)
      A_CTRL:  rdata_o = {14'd0, aux_q, disp_q};
      A_MODE:  rdata_o = {14'd0, stg_q.vs_low, stg_q.hs_low};
      A_IRQ:   rdata_o = {15'd0, irq_q};
      A_HCNT:  rdata_o = {stg_q.hact, stg_q.htot};
      A_VACT:  rdata_o = {4'd0, stg_q.vact};
      A_VTOT:  rdata_o = {4'd0, stg_q.vtot};
      A_VSYNC: rdata_o = {stg_q.vs_wid, stg_q.vs_beg};
      A_HSYNC: rdata_o = {stg_q.hs_wid, stg_q.hs_beg};
      A_PWR:   rdata_o = {14'd0, pwr_i};
      A_STEP:  rdata_o = step_q;
      default: rdata_o = '0;
    endcase
  end

  assign disp_on_o  = disp_q;
  assign aux_en_o   = aux_q;
  assign irq_en_o   = irq_q;
  assign step_dly_o = step_q;
  assign act_o      = act_q;

  assert_shadow_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(act_q));
endmodule

// File: rtl/lcdt_pwr_seq.sv
module lcdt_pwr_seq
  import lcdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             disp_on_i,
  input  logic [DLY_W-1:0] step_dly_i,
  output logic [PWR_W-1:0] state_o,
  output logic             run_o
);
  logic [PWR_W-1:0] state_q;
  logic [DLY_W-1:0] dcnt_q;
  logic go_up, go_dn;

  assign go_up = disp_on_i && (state_q != PWR_FULL);
  assign go_dn = !disp_on_i && (state_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      dcnt_q  <= '0;
    end else if (!(go_up || go_dn)) begin
      dcnt_q <= '0;
    end else if (dcnt_q == step_dly_i) begin
      dcnt_q  <= '0;
      state_q <= go_up ? state_q + 2'd1 : state_q - 2'd1;
    end else begin
      dcnt_q <= dcnt_q + 1'b1;
    end
  end

  assign state_o = state_q;
  assign run_o   = disp_on_i && (state_q == PWR_FULL);

  assert_one_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((state_q - $past(state_q)) != 2'd2));
  assert_no_wrap_up_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == 2'd0) |=> (state_q != 2'd3));
  assert_no_wrap_dn_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == 2'd3) |=> (state_q != 2'd0));
endmodule

// File: rtl/lcdt_scan.sv
module lcdt_scan
  import lcdt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  tmg_t              act_i,
  output logic [PIX_W-1:0]  pix_x_o,
  output logic [LINE_W-1:0] line_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic              frame_start_o,
  output logic              commit_o
);
  logic [CHAR_W-1:0] char_q;
  logic [SUB_W-1:0]  sub_q;
  logic [LINE_W-1:0] line_q;
  logic line_end, frame_end;
  logic [CMP_W-1:0] ch_c, ln_c, hs_b, hs_e, vs_b, vs_e;
  logic hs_on, vs_on;

  assign line_end  = (sub_q == '1) && (char_q == act_i.htot);
  assign frame_end = run_i && line_end && (line_q == act_i.vtot);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      char_q <= '0;
      sub_q  <= '0;
      line_q <= '0;
    end else if (!run_i) begin
      char_q <= '0;
      sub_q  <= '0;
      line_q <= '0;
    end else begin
      sub_q <= sub_q + 1'b1;
      if (line_end) begin
        char_q <= '0;
        line_q <= (line_q == act_i.vtot) ? '0 : line_q + 1'b1;
      end else if (sub_q == '1) begin
        char_q <= char_q + 1'b1;
      end
    end
  end

  // sync windows: start = field + 1, end = start + width field + 1
  assign ch_c  = {{(CMP_W-CHAR_W){1'b0}}, char_q};
  assign ln_c  = {{(CMP_W-LINE_W){1'b0}}, line_q};
  assign hs_b  = {1'b0, act_i.hs_beg} + 1'b1;
  assign hs_e  = hs_b + {{(CMP_W-WID_W){1'b0}}, act_i.hs_wid} + 1'b1;
  assign vs_b  = {1'b0, act_i.vs_beg} + 1'b1;
  assign vs_e  = vs_b + {{(CMP_W-WID_W){1'b0}}, act_i.vs_wid} + 1'b1;
  assign hs_on = run_i && (ch_c >= hs_b) && (ch_c < hs_e);
  assign vs_on = run_i && (ln_c >= vs_b) && (ln_c < vs_e);

  assign hsync_o       = hs_on ^ act_i.hs_low;
  assign vsync_o       = vs_on ^ act_i.vs_low;
  assign de_o          = run_i && (char_q <= act_i.hact) && (line_q <= act_i.vact);
  assign pix_x_o       = {char_q, sub_q};
  assign line_o        = line_q;
  assign frame_start_o = run_i && (char_q == '0) && (sub_q == '0) && (line_q == '0);
  assign commit_o      = !run_i || frame_end;

  assert_hold_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (pix_x_o == '0 && line_o == '0));
  assert_frame_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end |=> (line_o == '0 && pix_x_o == '0));
  assert_line_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i)) |-> (line_q <= act_i.vtot));
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcdt_pkg::*;
#(
  parameter logic [DLY_W-1:0] STEP_RST = 16'd3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic [PIX_W-1:0]  pix_x_o,
  output logic [LINE_W-1:0] line_o,
  output logic              irq_o,
  output logic              panel_en_o
);
  tmg_t act;
  logic disp_on, irq_en, run, commit, frame_start;
  logic [DLY_W-1:0] step_dly;
  logic [PWR_W-1:0] pwr;

  lcdt_regs #(.STEP_RST(STEP_RST)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .commit_i(commit), .pwr_i(pwr), .rdata_o(reg_rdata_o),
    .disp_on_o(disp_on), .aux_en_o(panel_en_o), .irq_en_o(irq_en),
    .step_dly_o(step_dly), .act_o(act)
  );

  lcdt_pwr_seq u_pwr (
    .clk_i, .rst_ni,
    .disp_on_i(disp_on), .step_dly_i(step_dly),
    .state_o(pwr), .run_o(run)
  );

  lcdt_scan u_scan (
    .clk_i, .rst_ni,
    .run_i(run), .act_i(act),
    .pix_x_o, .line_o, .hsync_o, .vsync_o, .de_o,
    .frame_start_o(frame_start), .commit_o(commit)
  );

  assign irq_o = irq_en && frame_start;

  assert_irq_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  assert_run_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> (pwr == PWR_FULL && disp_on));
endmodule

// File: tb/lcd_timing_gen_bench.sv
`timescale 1ns/1ps
module lcd_timing_gen_bench;
  localparam int WD_CYC = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0;
  logic [3:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic hs, vs, de, irq, pen;
  logic [10:0] px;
  logic [11:0] ln;

  int checks = 0, errors = 0, cur_n = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lcd_timing_gen u_lcd_timing_gen (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .hsync_o(hs), .vsync_o(vs), .de_o(de), .pix_x_o(px), .line_o(ln),
    .irq_o(irq), .panel_en_o(pen)
  );

  // {frame offset, pix, line, hs, vs, de}; 5 chars x 7 lines, active 16px x 3
  localparam logic [37:0] VEC [16] = '{
    {12'd0,   11'd0,  12'd0, 1'b0, 1'b0, 1'b1},
    {12'd15,  11'd15, 12'd0, 1'b0, 1'b0, 1'b1},
    {12'd16,  11'd16, 12'd0, 1'b0, 1'b0, 1'b0},
    {12'd24,  11'd24, 12'd0, 1'b1, 1'b0, 1'b0},
    {12'd31,  11'd31, 12'd0, 1'b1, 1'b0, 1'b0},
    {12'd32,  11'd32, 12'd0, 1'b0, 1'b0, 1'b0},
    {12'd39,  11'd39, 12'd0, 1'b0, 1'b0, 1'b0},
    {12'd40,  11'd0,  12'd1, 1'b0, 1'b0, 1'b1},
    {12'd95,  11'd15, 12'd2, 1'b0, 1'b0, 1'b1},
    {12'd125, 11'd5,  12'd3, 1'b0, 1'b0, 1'b0},
    {12'd160, 11'd0,  12'd4, 1'b0, 1'b1, 1'b0},
    {12'd184, 11'd24, 12'd4, 1'b1, 1'b1, 1'b0},
    {12'd239, 11'd39, 12'd5, 1'b0, 1'b1, 1'b0},
    {12'd240, 11'd0,  12'd6, 1'b0, 1'b0, 1'b0},
    {12'd279, 11'd39, 12'd6, 1'b0, 1'b0, 1'b0},
    {12'd280, 11'd0,  12'd0, 1'b0, 1'b0, 1'b1}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at n=%0d", req, act, exp, cur_n);
    end
  endtask

  task automatic step(int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      cur_n++;
    end
  endtask

  task automatic step_to(int n);
    step(n - cur_n);
  endtask

  task automatic wr_reg(logic [3:0] a, logic [15:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
    cur_n++;
  endtask

  task automatic rd_reg(logic [3:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 hsync", hs, 0); check("R1 vsync", vs, 0); check("R1 de", de, 0);
    check("R1 irq", irq, 0); check("R1 panel_en", pen, 0);
    check("R1 pix", px, 0); check("R1 line", ln, 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_reg(4'd8, r); check("R1 pwr", r, 0);
    rd_reg(4'd3, r); check("R1 hcnt", r, 0);
    rd_reg(4'd9, r); check("R1 step", r, 3);

    // R2 program geometry
    wr_reg(4'd3, 16'h0104);
    wr_reg(4'd4, 16'd2);
    wr_reg(4'd5, 16'd6);
    wr_reg(4'd6, 16'h1003);
    wr_reg(4'd7, 16'h0002);
    wr_reg(4'd1, 16'd0);
    wr_reg(4'd2, 16'd1);
    wr_reg(4'd9, 16'd4);
    wr_reg(4'd5, 16'hF006);
    rd_reg(4'd5, r); check("R2 vtot upper bits", r, 16'h0006);
    rd_reg(4'd6, r); check("R2 vsync field", r, 16'h1003);
    rd_reg(4'd3, r); check("R2 hcnt field", r, 16'h0104);

    // R11 write to power state ignored
    wr_reg(4'd8, 16'h0003);
    rd_reg(4'd8, r); check("R11 pwr write ignored", r, 0);
    check("R11 no scan", de, 0);

    // R7 power-up, R6 panel enable
    wr_reg(4'd0, 16'h0003);
    check("R6 panel_en", pen, 1);
    step(4); rd_reg(4'd8, r); check("R7 pwr before step", r, 0);
    step(1); rd_reg(4'd8, r); check("R7 pwr step1", r, 1);
    step(9); rd_reg(4'd8, r); check("R7 pwr step2", r, 2);
    check("R8 hsync idle", hs, 0); check("R8 de idle", de, 0); check("R8 pix idle", px, 0);
    step(1); rd_reg(4'd8, r); check("R7 pwr full", r, 3);
    check("R9 irq at first frame", irq, 1);
    cur_n = 0;

    // R3 R4 table walk
    for (int i = 0; i < 16; i++) begin
      step_to(int'(VEC[i][37:26]));
      check("R3 pix", px, VEC[i][25:15]);
      check("R3 line", ln, VEC[i][14:3]);
      check("R4 hsync", hs, VEC[i][2]);
      check("R4 vsync", vs, VEC[i][1]);
      check("R3 de", de, VEC[i][0]);
    end
    check("R9 irq frame start", irq, 1);
    step(1); check("R9 irq single cycle", irq, 0);

    // R10 mid-frame write waits for boundary; R5 polarity
    step_to(330);
    wr_reg(4'd1, 16'h0003);
    rd_reg(4'd1, r); check("R10 mode readback", r, 3);
    step_to(344); check("R10 old polarity hs", hs, 1); check("R10 old polarity vs", vs, 0);
    step_to(584); check("R5 hs active low", hs, 0); check("R5 vs idle high", vs, 1);
    step_to(592); check("R5 hs idle high", hs, 1);
    step_to(720); check("R5 vs active low", vs, 0);
    // R10 write in last cycle of frame
    step_to(839);
    wr_reg(4'd1, 16'h0000);
    check("R10 boundary vs", vs, 0);
    step_to(864); check("R10 boundary write hs", hs, 1);

    // R9 interrupt disable
    step_to(1000);
    wr_reg(4'd2, 16'd0);
    step_to(1120);
    check("R9 frame start pos", {px, ln}, 0);
    check("R9 irq disabled", irq, 0);

    // R7 R8 power-down
    step_to(1150);
    wr_reg(4'd0, 16'h0002);
    check("R8 de stops", de, 0);
    check("R6 panel_en kept", pen, 1);
    step(1); check("R8 pix held", px, 0); check("R8 line held", ln, 0);
    step(3); rd_reg(4'd8, r); check("R7 pwr hold 3", r, 3);
    step(1); rd_reg(4'd8, r); check("R7 pwr down 2", r, 2);
    step(10); rd_reg(4'd8, r); check("R7 pwr off", r, 0);
    check("R8 hsync off", hs, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(WD_CYC * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule